// File: doc/BRIEF.md
# Dual PWM/Timer with Synchronized Start

This block holds two identical 16-bit counting channels behind a byte-wide register port. Each channel works in one of two ways. As a timer it makes a square wave or a one-cycle pulse per count period. As a PWM generator its output is high for a programmable number of cycles in every control period. Each channel also drives an output-enable, which is deasserted while the channel is held in reset, and an interrupt request line.

The reset control of a channel is active-low: a channel stays cleared until its release bit is 1. A shared sync register masks that release for each channel separately. Software releases both channels first, then clears both sync bits in one write, and the two counters begin on the same clock. Channel 0 can also be reset from an external input, which acts either while it is held high or on its rising edge. Each channel records a rising output edge, a falling output edge, a stop event, and the end of a period with flat duty in a status register that clears when read. A global mask decides which channels raise an interrupt.

Top module: `dual_pwm_timer`

Register map: the registers of channel c start at c*8. Offset +0 is the control register. Offsets +1 and +2 hold the period, low and high byte. Offsets +3 and +4 hold the compare value, low and high byte. Offset +5 bit0 selects the timer shape (0 square, 1 pulse). Offset +6 is the status register. At 0x10, bits 0 and 1 are the sync masks and bit7 enables the external reset. At 0x11, bit c unmasks the interrupt of channel c.

## Requirements
- R1: After rst_n, every control register reads 00h, both output-enables are low, and both irq lines are low.
- R2: Control bit0 is an active-low release. While it is 0, the channel's counter is held at 0, its output is low and its output-enable is low. When it is 1 and nothing else holds the channel, the output-enable is high.
- R3: While it runs, the counter steps by one each clock and goes from the period value back to 0. In PWM mode (control bit7 = 1) the output is high while count < compare, so in every period+1 cycles it is high for min(compare, period+1) cycles.
- R4: In PWM mode the start bit (control bit2) has no effect. The channel counts with start = 0.
- R5: While sync bit c at 0x10 is 1, channel c is held as in R2. Clearing both sync bits in one write starts both counters from 0 on the same clock.
- R6: In timer mode with the square shape, the output is high while count < (period+1)/2 (integer division). With the pulse shape it is high only while count = period.
- R7: In timer mode with level start (control bit3 = 0), the counter advances only while start = 1. Clearing start freezes the counter and raises a stop event.
- R8: Status bits: bit0 = rising output edge (enabled by control bit4), bit1 = falling output edge (enabled by bit5), bit2 = stop event (enabled by bit6), bit3 = end of a flat-duty period. A read of the status register returns the bits and clears them. No event is recorded while the channel is held.
- R9: In PWM mode with compare 0 or FFFFh and the falling enable set, status bit3 is set each time the counter reaches the period value.
- R10: irq[c] is high exactly when status of channel c is nonzero and mask bit c at 0x11 is 1.
- R11: With bit7 of 0x10 set and control bit1 of channel 0 clear, ext_rst high holds channel 0 as in R2. With control bit1 set, a rising edge of ext_rst clears the counter for one clock and the output-enable stays high.
- R12: In timer mode with edge start (control bit3 = 1), a 0-to-1 change of start runs the counter through exactly one period back to 0. The counter then stops and raises a stop event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe; clears the status register it reads |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| ext_rst | input | 1 | External reset for channel 0 |
| pwm_out | output | 2 | Channel output values |
| pwm_oe | output | 2 | Channel output-enables; low means tri-state |
| irq | output | 2 | Masked interrupt request per channel |

## Verification
The bench uses the default of two channels, with the counter width fixed at 16 bits by the package. It uses periods between 3 and 15, so several complete periods fit in a few dozen cycles, and the duty count of each PWM vector can be checked over whole periods. Compare values of 0, values above the period and values equal to the period reach the flat-duty and always-high cases. Two channels are enough to check that both start together and that one channel stays held while the other is released.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  localparam int CNT_W = 16;
  localparam int BYTE_W = 8;
  localparam int ST_W = 4;
  localparam int ST_RISE = 0;
  localparam int ST_FALL = 1;
  localparam int ST_STOP = 2;
  localparam int ST_END  = 3;

  typedef struct packed {
    logic pwm_mode;
    logic en_stop;
    logic en_fall;
    logic en_rise;
    logic start_edge;
    logic start;
    logic rst_edge;
    logic release_n;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] c, logic [CNT_W-1:0] p);
    return (c == p) ? '0 : c + CNT_W'(1);
  endfunction

  function automatic logic square_level(logic [CNT_W-1:0] c, logic [CNT_W-1:0] p);
    logic [CNT_W:0] half;
    half = ({1'b0, p} + (CNT_W+1)'(1)) >> 1;
    return {1'b0, c} < half;
  endfunction

  function automatic logic pwm_level(logic [CNT_W-1:0] c, logic [CNT_W-1:0] cmp);
    return c < cmp;
  endfunction

  function automatic logic flat_duty(logic [CNT_W-1:0] cmp);
    return (cmp == '0) || (cmp == '1);
  endfunction
endpackage

// File: rtl/ptm_flags.sv
module ptm_flags #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         clr,
  output logic [W-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (clr ? '0 : flags) | ev;
  end
endmodule

// File: rtl/ptm_channel.sv
module ptm_channel
  import ptm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic             pulse_shape,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] compare,
  input  logic             hold,
  input  logic             clr,
  output logic             out,
  output logic             oe,
  output logic             set_o,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [ST_W-1:0]  events
);
  logic             set, run, run_d, out_d, start_d, shot, go, run_timer, level;
  logic [CNT_W-1:0] cnt;

  assign set       = ~hold;
  assign go        = ctrl.start & ~start_d;
  assign run_timer = ctrl.start_edge ? (shot | go) : ctrl.start;
  assign run       = set & (ctrl.pwm_mode | run_timer);

  always_comb begin
    if (ctrl.pwm_mode)  level = pwm_level(cnt, compare);
    else if (pulse_shape) level = (cnt == period);
    else                level = square_level(cnt, period);
  end

  assign out   = set & level;
  assign oe    = set;
  assign set_o = set;
  assign run_o = run;
  assign cnt_o = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; run_d <= 1'b0; out_d <= 1'b0; start_d <= 1'b0; shot <= 1'b0;
    end else if (!set) begin
      cnt <= '0; run_d <= 1'b0; out_d <= 1'b0; start_d <= 1'b0; shot <= 1'b0;
    end else begin
      run_d   <= run;
      out_d   <= out;
      start_d <= ctrl.start;
      if (go && ctrl.start_edge)                 shot <= 1'b1;
      else if (shot && run && cnt == period)     shot <= 1'b0;
      if (clr)      cnt <= '0;
      else if (run) cnt <= next_count(cnt, period);
    end
  end

  always_comb begin
    events          = '0;
    events[ST_RISE] = set & ctrl.en_rise & out & ~out_d;
    events[ST_FALL] = set & ctrl.en_fall & ~out & out_d;
    events[ST_STOP] = set & ctrl.en_stop & run_d & ~run;
    events[ST_END]  = set & ctrl.en_fall & ctrl.pwm_mode & flat_duty(compare) & run & (cnt == period);
  end
endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
  import ptm_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CH_SPAN = 8,
  localparam int SHARED = NCH * CH_SPAN,
  localparam int ADDR_W = $clog2(SHARED + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              ext_rst,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    pwm_oe,
  output logic [NCH-1:0]    irq
);
  localparam int OFF_CTRL = 0, OFF_PLO = 1, OFF_PHI = 2, OFF_CLO = 3, OFF_CHI = 4;
  localparam int OFF_SHAPE = 5, OFF_STAT = 6;
  localparam int A_SYNC = SHARED, A_MASK = SHARED + 1;

  ctrl_t            ctrl_q  [NCH];
  logic [CNT_W-1:0] per_q   [NCH];
  logic [CNT_W-1:0] cmp_q   [NCH];
  logic [NCH-1:0]   shape_q, sync_q, mask_q, stat_clr;
  logic             ext_en_q, ext_d;
  logic [ST_W-1:0]  ev      [NCH];
  logic [ST_W-1:0]  stat_q  [NCH];

  // internal views for the checker
  logic [NCH-1:0]       set_w, run_w, clr_w, pwm_w, hold_w;
  logic [NCH*CNT_W-1:0] cnt_w, per_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        ctrl_q[c] <= '0; per_q[c] <= '0; cmp_q[c] <= '0;
      end
      shape_q <= '0; sync_q <= '0; mask_q <= '0; ext_en_q <= 1'b0; ext_d <= 1'b0;
    end else begin
      ext_d <= ext_rst;
      if (wr_en) begin
        for (int c = 0; c < NCH; c++) begin
          if (wr_addr == ADDR_W'(c*CH_SPAN + OFF_CTRL))  ctrl_q[c]       <= ctrl_t'(wr_data);
          if (wr_addr == ADDR_W'(c*CH_SPAN + OFF_PLO))   per_q[c][7:0]   <= wr_data;
          if (wr_addr == ADDR_W'(c*CH_SPAN + OFF_PHI))   per_q[c][15:8]  <= wr_data;
          if (wr_addr == ADDR_W'(c*CH_SPAN + OFF_CLO))   cmp_q[c][7:0]   <= wr_data;
          if (wr_addr == ADDR_W'(c*CH_SPAN + OFF_CHI))   cmp_q[c][15:8]  <= wr_data;
          if (wr_addr == ADDR_W'(c*CH_SPAN + OFF_SHAPE)) shape_q[c]      <= wr_data[0];
        end
        if (wr_addr == ADDR_W'(A_SYNC)) begin
          sync_q   <= wr_data[NCH-1:0];
          ext_en_q <= wr_data[7];
        end
        if (wr_addr == ADDR_W'(A_MASK)) mask_q <= wr_data[NCH-1:0];
      end
    end
  end

  always_comb begin
    rd_data  = '0;
    stat_clr = '0;
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr == ADDR_W'(c*CH_SPAN + OFF_CTRL))  rd_data = ctrl_q[c];
      if (rd_addr == ADDR_W'(c*CH_SPAN + OFF_PLO))   rd_data = per_q[c][7:0];
      if (rd_addr == ADDR_W'(c*CH_SPAN + OFF_PHI))   rd_data = per_q[c][15:8];
      if (rd_addr == ADDR_W'(c*CH_SPAN + OFF_CLO))   rd_data = cmp_q[c][7:0];
      if (rd_addr == ADDR_W'(c*CH_SPAN + OFF_CHI))   rd_data = cmp_q[c][15:8];
      if (rd_addr == ADDR_W'(c*CH_SPAN + OFF_SHAPE)) rd_data = {7'd0, shape_q[c]};
      if (rd_addr == ADDR_W'(c*CH_SPAN + OFF_STAT)) begin
        rd_data     = BYTE_W'(stat_q[c]);
        stat_clr[c] = rd_en;
      end
    end
    if (rd_addr == ADDR_W'(A_SYNC)) begin
      rd_data          = '0;
      rd_data[NCH-1:0] = sync_q;
      rd_data[7]       = ext_en_q;
    end
    if (rd_addr == ADDR_W'(A_MASK)) rd_data = BYTE_W'(mask_q);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c == 0) begin : g_ext
      assign hold_w[c] = ~ctrl_q[c].release_n | sync_q[c]
                       | (ext_en_q & ~ctrl_q[c].rst_edge & ext_rst);
      assign clr_w[c]  = ext_en_q & ctrl_q[c].rst_edge & ext_rst & ~ext_d;
    end else begin : g_plain
      assign hold_w[c] = ~ctrl_q[c].release_n | sync_q[c];
      assign clr_w[c]  = 1'b0;
    end

    ptm_channel u_ch (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q[c]), .pulse_shape(shape_q[c]),
      .period(per_q[c]), .compare(cmp_q[c]), .hold(hold_w[c]), .clr(clr_w[c]),
      .out(pwm_out[c]), .oe(pwm_oe[c]), .set_o(set_w[c]), .run_o(run_w[c]),
      .cnt_o(cnt_w[c*CNT_W +: CNT_W]), .events(ev[c])
    );

    ptm_flags #(.W(ST_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .ev(ev[c]), .clr(stat_clr[c]), .flags(stat_q[c])
    );

    assign pwm_w[c]                  = ctrl_q[c].pwm_mode;
    assign per_w[c*CNT_W +: CNT_W]   = per_q[c];
    assign irq[c]                    = mask_q[c] & (|stat_q[c]);
  end
endmodule

// File: rtl/ptm_checker.sv
module ptm_checker
  import ptm_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH-1:0]       pwm_out,
  input logic [NCH-1:0]       pwm_oe,
  input logic [NCH-1:0]       irq,
  input logic [NCH-1:0]       mask,
  input logic [NCH-1:0]       set_v,
  input logic [NCH-1:0]       run_v,
  input logic [NCH-1:0]       clr_v,
  input logic [NCH-1:0]       pwm_v,
  input logic [NCH*CNT_W-1:0] cnt_v,
  input logic [NCH*CNT_W-1:0] per_v
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    logic [CNT_W-1:0] cnt, per;
    assign cnt = cnt_v[i*CNT_W +: CNT_W];
    assign per = per_v[i*CNT_W +: CNT_W];

    assert_out_tristate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_oe[i] |-> !pwm_out[i]);

    assert_release_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(set_v[i]) |-> (cnt == '0));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v[i] && run_v[i] && !clr_v[i] && cnt == per) |=> (cnt == '0));

    assert_pwm_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v[i] && pwm_v[i] && !clr_v[i] && cnt != per) |=> (cnt == $past(cnt) + CNT_W'(1)));

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> mask[i]);
  end
endmodule

bind dual_pwm_timer ptm_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .pwm_oe(pwm_oe), .irq(irq),
  .mask(mask_q), .set_v(set_w), .run_v(run_w), .clr_v(clr_w), .pwm_v(pwm_w),
  .cnt_v(cnt_w), .per_v(per_w)
);

// File: tb/sim_dual_pwm_timer.sv
module sim_dual_pwm_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, ext_rst = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] pwm_out, pwm_oe, irq;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dual_pwm_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ext_rst(ext_rst),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .irq(irq)
  );

  // {period, compare, expected high cycles per period}
  localparam logic [47:0] VEC [0:6] = '{
    {16'd9,  16'd3,  16'd3},
    {16'd9,  16'd0,  16'd0},
    {16'd4,  16'd5,  16'd5},
    {16'd7,  16'd7,  16'd7},
    {16'd3,  16'd1,  16'd1},
    {16'd15, 16'd8,  16'd8},
    {16'd9,  16'd10, 16'd10}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic setup(int ch, logic [15:0] per, logic [15:0] cmp);
    wr(5'(ch*8 + 0), 8'h00);
    wr(5'(ch*8 + 1), per[7:0]);
    wr(5'(ch*8 + 2), per[15:8]);
    wr(5'(ch*8 + 3), cmp[7:0]);
    wr(5'(ch*8 + 4), cmp[15:8]);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int hi, mism;
    logic keep;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(5'd0, d);  chk("R1 ctrl0", d, 8'h00);
    rd(5'd8, d);  chk("R1 ctrl1", d, 8'h00);
    chk("R1 oe", pwm_oe, 2'b00);
    chk("R1 irq", irq, 2'b00);

    // R3 / R4 table of PWM vectors, start bit left at 0
    for (int v = 0; v < 7; v++) begin
      logic [15:0] p, c, e;
      {p, c, e} = VEC[v];
      setup(0, p, c);
      wr(5'd0, 8'h81);
      hi = 0;
      for (int i = 0; i < 2*(p+1); i++) begin
        if (pwm_out[0]) hi++;
        @(negedge clk);
      end
      chk("R3 R4 pwm duty", hi, 2*e);
      chk("R2 oe released", pwm_oe[0], 1'b1);
    end

    // R2 release bit low holds channel
    wr(5'd0, 8'h80);
    keep = 1'b0;
    for (int i = 0; i < 8; i++) begin
      keep |= pwm_out[0] | pwm_oe[0];
      @(negedge clk);
    end
    chk("R2 held", keep, 1'b0);

    // R5 synchronized start
    wr(5'h10, 8'h03);
    setup(0, 16'd9, 16'd4);
    setup(1, 16'd9, 16'd4);
    wr(5'd0, 8'h81);
    wr(5'd8, 8'h81);
    chk("R5 masked oe", pwm_oe, 2'b00);
    wr(5'h10, 8'h01);
    chk("R5 only ch1 released", pwm_oe, 2'b10);
    wr(5'd8, 8'h80);
    wr(5'd8, 8'h81);
    wr(5'h10, 8'h03);
    step(2);
    wr(5'h10, 8'h00);
    mism = 0;
    for (int i = 0; i < 10; i++) begin
      if (pwm_out[0] !== pwm_out[1] || pwm_out[0] !== (i < 4)) mism++;
      @(negedge clk);
    end
    chk("R5 both start together", mism, 0);
    chk("R5 oe both", pwm_oe, 2'b11);
    wr(5'd8, 8'h00);

    // R6 square and R7 level start
    setup(0, 16'd7, 16'd0);
    wr(5'd0, 8'h01);
    keep = 1'b1;
    for (int i = 0; i < 10; i++) begin
      keep &= pwm_out[0];
      @(negedge clk);
    end
    chk("R7 no count without start", keep, 1'b1);
    rd(5'd6, d);
    wr(5'd0, 8'h45);
    mism = 0;
    for (int i = 0; i < 16; i++) begin
      if (pwm_out[0] !== ((i % 8) < 4)) mism++;
      @(negedge clk);
    end
    chk("R6 square wave", mism, 0);
    step(2);
    wr(5'd0, 8'h41);
    keep = pwm_out[0];
    mism = 0;
    for (int i = 0; i < 8; i++) begin
      if (pwm_out[0] !== keep) mism++;
      @(negedge clk);
    end
    chk("R7 frozen after stop", mism, 0);
    rd(5'd6, d); chk("R7 R8 stop flag", d, 8'h04);

    // R6 pulse shape
    setup(0, 16'd5, 16'd0);
    wr(5'd5, 8'h01);
    wr(5'd0, 8'h05);
    mism = 0;
    for (int i = 0; i < 12; i++) begin
      if (pwm_out[0] !== ((i % 6) == 5)) mism++;
      @(negedge clk);
    end
    chk("R6 pulse shape", mism, 0);
    wr(5'd5, 8'h00);

    // R12 edge start one-shot
    setup(0, 16'd3, 16'd0);
    rd(5'd6, d);
    wr(5'd0, 8'h4D);
    mism = 0;
    for (int i = 0; i < 10; i++) begin
      if (pwm_out[0] !== (i >= 4 || i < 2)) mism++;
      @(negedge clk);
    end
    chk("R12 one period then stop", mism, 0);
    rd(5'd6, d); chk("R12 stop flag", d, 8'h04);

    // R8 rise/fall flags and clear on read
    setup(0, 16'd9, 16'd3);
    rd(5'd6, d);
    wr(5'd0, 8'hB1);
    step(12);
    wr(5'd0, 8'hB0);
    rd(5'd6, d); chk("R8 rise fall flags", d, 8'h03);
    rd(5'd6, d); chk("R8 cleared by read", d, 8'h00);

    // R9 flat duty period end, R10 masking
    setup(0, 16'd4, 16'd0);
    wr(5'd0, 8'hA1);
    step(12);
    chk("R10 masked irq low", irq, 2'b00);
    wr(5'h11, 8'h01);
    chk("R10 irq with mask", irq, 2'b01);
    wr(5'd0, 8'hA0);
    rd(5'd6, d); chk("R9 period end flag", d, 8'h08);
    chk("R10 irq clears", irq, 2'b00);
    wr(5'h11, 8'h00);

    // R11 external reset, level then edge
    setup(0, 16'd9, 16'd5);
    wr(5'h10, 8'h80);
    wr(5'd0, 8'h81);
    step(3);
    ext_rst = 1'b1;
    step(2);
    chk("R11 level hold oe", pwm_oe[0], 1'b0);
    ext_rst = 1'b0;
    #1 chk("R11 level release oe", pwm_oe[0], 1'b1);
    wr(5'd0, 8'h83);
    for (int i = 0; i < 20 && pwm_out[0]; i++) @(negedge clk);
    chk("R11 reached low phase", pwm_out[0], 1'b0);
    ext_rst = 1'b1;
    step(1);
    chk("R11 edge clears counter", pwm_out[0], 1'b1);
    chk("R11 edge keeps oe", pwm_oe[0], 1'b1);
    step(1);
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      if (pwm_out[0]) hi++;
      @(negedge clk);
    end
    chk("R11 single clear on edge", hi, 5);
    ext_rst = 1'b0;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule